// File: doc/BRIEF.md
# Interrupt CPU Interface Unit

This block is the per-processor end of an interrupt controller. A distributor supplies a set of candidate interrupts: a pending bit, a group bit and an 8-bit priority for each one, plus a source-processor number for each software-generated interrupt. The unit picks the best candidate that may be signalled and drives one of two request lines, a normal request (`irq_o`) or a fast request (`fiq_o`). Software works through a small memory-mapped register port. It reads an acknowledge register to claim the interrupt, runs its handler, and then writes the claimed word back to an end-of-interrupt register.

A small stack of active interrupts tracks the running priority. An interrupt can take over from a running one only when its priority value is strictly below the running priority. The stack controller is a three-state machine:
- EMPTY: nothing is active and the running priority is 0xFF.
- PARTIAL: at least one interrupt is active and there is room for another.
- FULL: all entries are in use and nothing is signalled.

The stack has these transitions:
- EMPTY to PARTIAL on ACK_PUSH (to FULL when the depth is one).
- PARTIAL to FULL on ACK_PUSH of the last free entry.
- PARTIAL to EMPTY on EOI_POP of the last entry.
- FULL to PARTIAL on EOI_POP (to EMPTY when the depth is one).
- Every state holds when there is neither a push nor a matching pop.

Each successful acknowledge sends a one-cycle pulse with the interrupt ID back to the distributor, which then clears that pending bit.

Top module: `intc_cpu_iface`

## Requirements
- R1: After reset, the control and mask registers read 0, no interrupt is active, and `irq_o`, `fiq_o` and `ack_valid_o` are low.
- R2: Reads return data in `bus_rdata` with `bus_rvalid` high on the cycle after the request.
  - Control sits at address 0x000. Bit 0 enables group 0, bit 1 enables group 1, and bit 3 sends group 0 to `fiq_o`. All other bits read 0.
  - The priority mask sits at address 0x004 and holds bits [7:0].
  - Any other address reads 0.
- R3: A candidate qualifies only when four conditions all hold:
  - it is pending;
  - its group is enabled;
  - its priority is numerically below the mask;
  - its priority is numerically below the running priority.
  The request outputs reflect the inputs one cycle later.
- R4: The best candidate drives `fiq_o` when it is in group 0 and control bit 3 is set. Otherwise it drives `irq_o`. The two outputs are never high together.
- R5: The best candidate is the one with the lowest priority value. On a tie, the lowest ID wins. This holds even when the candidate appears in the same cycle as the acknowledge read.
- R6: A read of address 0x00C with a qualifying candidate does three things:
  - it returns the ID in bits [9:0];
  - it pushes the candidate onto the active stack, so the running priority becomes its priority;
  - on the next cycle it pulses `ack_valid_o` with `ack_id_o` equal to that ID.
- R7: Bits [12:10] of the acknowledge word carry the source processor from `sgi_src` for IDs below `NUM_SGI`, and 0 for other IDs.
- R8: With no qualifying candidate, an acknowledge read returns ID 1023 and source 0, gives no pulse, and changes no state.
- R9: A write to address 0x010 whose bits [9:0] match the most recently acknowledged active ID retires it. The running priority goes back to that of the entry below, or to 0xFF when the stack is empty.
- R10: An end-of-interrupt write whose ID does not match the top active ID is ignored.
- R11: When the active stack is full, nothing is signalled and acknowledge reads return 1023.
- R12: With control bits 0 and 1 both clear, neither request output is raised and acknowledge reads return 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Marks `bus_rdata` as valid |
| cand_pend | input | NUM_INT | Pending bit for each interrupt ID |
| cand_group | input | NUM_INT | Group of each ID (0 or 1) |
| cand_prio | input | NUM_INT*8 | Priority of each ID; ID i in bits [8i+7:8i] |
| sgi_src | input | NUM_SGI*3 | Source processor of each software-generated ID |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| ack_valid_o | output | 1 | One-cycle pulse after a successful acknowledge |
| ack_id_o | output | 10 | ID that was acknowledged |

## Verification
An acknowledge read can land in the same cycle as a change to the distributor's candidates. The read must then choose among the inputs present at that clock edge, not those of the cycle before. The bench provokes this by raising a new, better candidate on the very cycle it issues the acknowledge read. It then expects that candidate's ID in the read data and in the acknowledge pulse. An end-of-interrupt write can also coincide with a pending candidate whose priority sits exactly at the running priority. The bench's behavioural model decides that case every clock from the requirements alone. A long stretch of random candidates and register accesses then compares both request lines, the acknowledge pulse and all read data against that model on every cycle.

// File: rtl/icpu_pkg.sv
`timescale 1ns/1ps
package icpu_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    localparam logic [11:0] ADDR_CTRL = 12'h000;
    localparam logic [11:0] ADDR_MASK = 12'h004;
    localparam logic [11:0] ADDR_ACK  = 12'h00C;
    localparam logic [11:0] ADDR_EOI  = 12'h010;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } stk_state_e;
endpackage

// File: rtl/icpu_select.sv
`timescale 1ns/1ps
module icpu_select import icpu_pkg::*; #(
    parameter int NUM_INT = 32,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_INT-1:0]        pend,
    input  logic [NUM_INT-1:0]        group,
    input  logic [NUM_INT*PRIO_W-1:0] prio,
    input  logic [1:0]                grp_en,
    input  logic [PRIO_W-1:0]         mask,
    input  logic [PRIO_W-1:0]         running,
    output logic                      found,
    output logic [ID_W-1:0]           best_id,
    output logic [PRIO_W-1:0]         best_prio,
    output logic                      best_group
);
    // Linear scan: strict less-than keeps the lowest ID on equal priority.
    always_comb begin
        found      = 1'b0;
        best_id    = '0;
        best_prio  = '1;
        best_group = 1'b0;
        for (int i = 0; i < NUM_INT; i++) begin
            logic [PRIO_W-1:0] p;
            logic              ok;
            p  = prio[i*PRIO_W +: PRIO_W];
            ok = pend[i] && grp_en[group[i]] && (p < mask) && (p < running);
            if (ok && (!found || p < best_prio)) begin
                found      = 1'b1;
                best_id    = ID_W'(i);
                best_prio  = p;
                best_group = group[i];
            end
        end
    end
endmodule

// File: rtl/icpu_active_stack.sv
`timescale 1ns/1ps
module icpu_active_stack import icpu_pkg::*; #(
    parameter int DEPTH  = 2,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop_req,
    input  logic [ID_W-1:0]   pop_id,
    output logic [PRIO_W-1:0] running_prio,
    output logic [ID_W-1:0]   top_id,
    output logic              full,
    output logic              empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    stk_state_e         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [ID_W-1:0]    id_mem   [DEPTH];
    logic [PRIO_W-1:0]  prio_mem [DEPTH];
    logic [PRIO_W-1:0]  top_prio;
    logic               push_eff, pop_eff;

    assign full     = (state_q == ST_FULL);
    assign empty    = (state_q == ST_EMPTY);
    assign push_eff = push && !full;
    assign pop_eff  = pop_req && !empty && (pop_id == top_id);

    always_comb begin
        top_id   = '0;
        top_prio = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNT_W'(i + 1)) begin
                top_id   = id_mem[i];
                top_prio = prio_mem[i];
            end
        end
    end
    assign running_prio = empty ? '1 : top_prio;

    // Next-state logic: ACK_PUSH and EOI_POP transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:
                if (push_eff) state_d = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;
            ST_PARTIAL:
                if (push_eff && cnt_q == CNT_W'(DEPTH - 1)) state_d = ST_FULL;
                else if (pop_eff && cnt_q == CNT_W'(1))   state_d = ST_EMPTY;
            ST_FULL:
                if (pop_eff) state_d = (DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;
            default:
                state_d = ST_EMPTY;
        endcase
    end

    // State register and occupancy.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (push_eff)     cnt_q <= cnt_q + CNT_W'(1);
            else if (pop_eff) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                id_mem[g]   <= '0;
                prio_mem[g] <= '1;
            end else if (push_eff && cnt_q == CNT_W'(g)) begin
                id_mem[g]   <= push_id;
                prio_mem[g] <= push_prio;
            end
        end
    end

    assert_push_sets_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_eff |=> running_prio == $past(push_prio));
    assert_bad_eoi_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !empty && pop_id != top_id && !push) |=> $stable(cnt_q) && $stable(running_prio));
    assert_no_push_when_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    assert_last_pop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && pop_id == top_id && cnt_q == CNT_W'(1)) |=> (empty && running_prio == '1));
endmodule

// File: rtl/intc_cpu_iface.sv
`timescale 1ns/1ps
module intc_cpu_iface import icpu_pkg::*; #(
    parameter int NUM_INT   = 32,
    parameter int PRIO_W    = 8,
    parameter int ACT_DEPTH = 2,
    parameter int NUM_SGI   = 16,
    parameter int SRC_W     = 3,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      bus_rvalid,
    input  logic [NUM_INT-1:0]        cand_pend,
    input  logic [NUM_INT-1:0]        cand_group,
    input  logic [NUM_INT*PRIO_W-1:0] cand_prio,
    input  logic [NUM_SGI*SRC_W-1:0]  sgi_src,
    output logic                      irq_o,
    output logic                      fiq_o,
    output logic                      ack_valid_o,
    output logic [ID_W-1:0]           ack_id_o
);
    localparam int PAD_W = DATA_W - ID_W - SRC_W;

    logic              grp0_en_q, grp1_en_q, fiq_route_q;
    logic [PRIO_W-1:0] mask_q;
    logic              rd, wr, rd_ack, take, wr_eoi;
    logic              sel_found, sel_group;
    logic [ID_W-1:0]   sel_id, top_id;
    logic [PRIO_W-1:0] sel_prio, running_prio;
    logic              stk_full, stk_empty;
    logic [SRC_W-1:0]  sel_src;
    logic [DATA_W-1:0] rdata_d;
    logic              unused_ok;

    assign unused_ok = ^{bus_wdata, stk_empty};

    assign rd     = bus_valid && !bus_write;
    assign wr     = bus_valid && bus_write;
    assign rd_ack = rd && (bus_addr == ADDR_W'(ADDR_ACK));
    assign wr_eoi = wr && (bus_addr == ADDR_W'(ADDR_EOI));
    assign take   = rd_ack && sel_found && !stk_full;

    icpu_select #(.NUM_INT(NUM_INT), .PRIO_W(PRIO_W)) u_select (
        .pend      (cand_pend),
        .group     (cand_group),
        .prio      (cand_prio),
        .grp_en    ({grp1_en_q, grp0_en_q}),
        .mask      (mask_q),
        .running   (running_prio),
        .found     (sel_found),
        .best_id   (sel_id),
        .best_prio (sel_prio),
        .best_group(sel_group)
    );

    icpu_active_stack #(.DEPTH(ACT_DEPTH), .PRIO_W(PRIO_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (take),
        .push_id     (sel_id),
        .push_prio   (sel_prio),
        .pop_req     (wr_eoi),
        .pop_id      (bus_wdata[ID_W-1:0]),
        .running_prio(running_prio),
        .top_id      (top_id),
        .full        (stk_full),
        .empty       (stk_empty)
    );

    always_comb begin
        sel_src = '0;
        for (int i = 0; i < NUM_SGI; i++)
            if (sel_id == ID_W'(i)) sel_src = sgi_src[i*SRC_W +: SRC_W];
    end

    always_comb begin
        rdata_d = '0;
        unique case (bus_addr)
            ADDR_W'(ADDR_CTRL): rdata_d = DATA_W'({fiq_route_q, 1'b0, grp1_en_q, grp0_en_q});
            ADDR_W'(ADDR_MASK): rdata_d = DATA_W'(mask_q);
            ADDR_W'(ADDR_ACK):  rdata_d = take ? {{PAD_W{1'b0}}, sel_src, sel_id}
                                               : {{PAD_W{1'b0}}, {SRC_W{1'b0}}, SPURIOUS_ID};
            default:            rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp0_en_q   <= 1'b0;
            grp1_en_q   <= 1'b0;
            fiq_route_q <= 1'b0;
            mask_q      <= '0;
        end else if (wr) begin
            if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
                grp0_en_q   <= bus_wdata[0];
                grp1_en_q   <= bus_wdata[1];
                fiq_route_q <= bus_wdata[3];
            end
            if (bus_addr == ADDR_W'(ADDR_MASK)) mask_q <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata   <= '0;
            bus_rvalid  <= 1'b0;
            irq_o       <= 1'b0;
            fiq_o       <= 1'b0;
            ack_valid_o <= 1'b0;
            ack_id_o    <= '0;
        end else begin
            bus_rvalid  <= rd;
            bus_rdata   <= rd ? rdata_d : '0;
            irq_o       <= sel_found && !stk_full && !(!sel_group && fiq_route_q);
            fiq_o       <= sel_found && !stk_full && !sel_group && fiq_route_q;
            ack_valid_o <= take;
            ack_id_o    <= take ? sel_id : '0;
        end
    end

    assert_one_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && fiq_o));
    assert_groups_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp0_en_q && !grp1_en_q) |=> (!irq_o && !fiq_o));
    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (ack_valid_o && ack_id_o == $past(sel_id)));
    assert_spurious_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !take) |=> (!ack_valid_o && bus_rdata[ID_W-1:0] == SPURIOUS_ID));
    assert_full_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |=> (!irq_o && !fiq_o));
endmodule

// File: tb/tb_intc_cpu_iface.sv
`timescale 1ns/1ps
module tb_intc_cpu_iface;
    localparam int N = 32, PW = 8, DEPTH = 2, NSGI = 16, SW = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [N-1:0]      cand_pend = '0, cand_group = '0;
    logic [N*PW-1:0]   cand_prio = '1;
    logic [NSGI*SW-1:0] sgi_src = '0;
    logic              irq_o, fiq_o, ack_valid_o;
    logic [9:0]        ack_id_o;

    intc_cpu_iface dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cand_pend(cand_pend), .cand_group(cand_group),
        .cand_prio(cand_prio), .sgi_src(sgi_src), .irq_o(irq_o), .fiq_o(fiq_o),
        .ack_valid_o(ack_valid_o), .ack_id_o(ack_id_o)
    );

    int errors = 0, checks = 0;
    bit chk_on = 0;
    string cur_tag = "R2";

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int  stk_id[$], stk_pr[$];
    bit  m_g0, m_g1, m_fr;
    int  m_mask;
    bit  e_irq, e_fiq, e_ackv, e_rvalid;
    int  e_ackid;
    longint e_rdata;
    string e_tag = "R2";

    always @(posedge clk) begin
        if (!rst_n) begin
            stk_id.delete(); stk_pr.delete();
            m_g0 = 0; m_g1 = 0; m_fr = 0; m_mask = 0;
            e_irq = 0; e_fiq = 0; e_ackv = 0; e_ackid = 0; e_rvalid = 0; e_rdata = 0;
        end else begin
            int run, best, bp;
            bit full;
            run  = (stk_pr.size() == 0) ? 255 : stk_pr[$];
            full = (stk_id.size() == DEPTH);
            best = -1; bp = 256;
            for (int i = 0; i < N; i++) begin
                int p;
                bit en;
                p  = int'(cand_prio[i*PW +: PW]);
                en = cand_group[i] ? m_g1 : m_g0;
                if (cand_pend[i] && en && p < m_mask && p < run && p < bp) begin
                    best = i; bp = p;
                end
            end
            e_irq = 0; e_fiq = 0; e_ackv = 0; e_rvalid = 0; e_rdata = 0;
            if (best >= 0 && !full) begin
                if (!cand_group[best] && m_fr) e_fiq = 1; else e_irq = 1;
            end
            if (bus_valid && !bus_write) begin
                e_rvalid = 1;
                e_tag = cur_tag;
                case (bus_addr)
                    12'h000: e_rdata = {m_fr, 1'b0, m_g1, m_g0};
                    12'h004: e_rdata = m_mask;
                    12'h00C: begin
                        if (best >= 0 && !full) begin
                            int src;
                            src = (best < NSGI) ? int'(sgi_src[best*SW +: SW]) : 0;
                            e_rdata = best | (src << 10);
                            stk_id.push_back(best); stk_pr.push_back(bp);
                            e_ackv = 1; e_ackid = best;
                        end else e_rdata = 1023;
                    end
                    default: e_rdata = 0;
                endcase
            end else if (bus_valid && bus_write) begin
                case (bus_addr)
                    12'h000: begin m_g0 = bus_wdata[0]; m_g1 = bus_wdata[1]; m_fr = bus_wdata[3]; end
                    12'h004: m_mask = int'(bus_wdata[7:0]);
                    12'h010: if (stk_id.size() > 0 && stk_id[$] == int'(bus_wdata[9:0])) begin
                        void'(stk_id.pop_back()); void'(stk_pr.pop_back());
                    end
                    default: ;
                endcase
            end
        end
    end

    // Cycle compare and distributor behaviour (pending cleared on acknowledge)
    always @(negedge clk) begin
        if (chk_on) begin
            check(irq_o == e_irq, "R3 irq", irq_o, e_irq);
            check(fiq_o == e_fiq, "R4 fiq", fiq_o, e_fiq);
            check(ack_valid_o == e_ackv, "R6 ack pulse", ack_valid_o, e_ackv);
            if (e_ackv) check(ack_id_o == e_ackid, "R6 ack id", ack_id_o, e_ackid);
            check(bus_rvalid == e_rvalid, "R2 rvalid", bus_rvalid, e_rvalid);
            if (e_rvalid) check(bus_rdata == e_rdata, e_tag, bus_rdata, e_rdata);
        end
        if (ack_valid_o) cand_pend[ack_id_o] = 1'b0;
    end

    task automatic wr_reg(logic [11:0] a, logic [31:0] d);
        @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd_expect(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a; cur_tag = tag;
        @(negedge clk); bus_valid = 0;
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic set_int(int id, int p, bit g, bit pnd);
        @(negedge clk);
        cand_prio[id*PW +: PW] = PW'(p); cand_group[id] = g; cand_pend[id] = pnd;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);
        check(irq_o == 0 && fiq_o == 0 && ack_valid_o == 0, "R1 outputs idle", {irq_o, fiq_o, ack_valid_o}, 0);
        chk_on = 1;
        rd_expect(12'h000, 32'h0, "R1 ctrl");
        rd_expect(12'h004, 32'h0, "R1 mask");
        rd_expect(12'h00C, 32'd1023, "R1 nothing active");

        wr_reg(12'h000, 32'hFF);
        rd_expect(12'h000, 32'h0B, "R2 ctrl readback");
        wr_reg(12'h004, 32'h180);
        rd_expect(12'h004, 32'h80, "R2 mask readback");
        rd_expect(12'h020, 32'h0, "R2 other address");

        set_int(5, 'h40, 1, 1); wait_cyc(2);
        check(irq_o == 1 && fiq_o == 0, "R3 group1 raises irq", {irq_o, fiq_o}, 2'b10);
        set_int(3, 'h40, 0, 1); wait_cyc(2);
        check(fiq_o == 1 && irq_o == 0, "R5 tie to lower id on fiq", {irq_o, fiq_o}, 2'b01);
        set_int(8, 'h90, 1, 1); wait_cyc(2);

        rd_expect(12'h00C, 32'd3, "R6 acknowledge id 3");
        wait_cyc(2);
        check(irq_o == 0 && fiq_o == 0, "R3 equal to running blocked", {irq_o, fiq_o}, 0);
        set_int(7, 'h10, 1, 1); wait_cyc(2);
        check(irq_o == 1, "R3 higher priority preempts", irq_o, 1);
        rd_expect(12'h00C, 32'd7, "R6 acknowledge id 7");
        wait_cyc(2);
        set_int(11, 'h01, 1, 1); wait_cyc(2);
        check(irq_o == 0 && fiq_o == 0, "R11 full stack silent", {irq_o, fiq_o}, 0);
        rd_expect(12'h00C, 32'd1023, "R11 full stack spurious");
        set_int(11, 'h01, 1, 0);

        wr_reg(12'h010, 32'd3);
        rd_expect(12'h00C, 32'd1023, "R10 mismatched eoi ignored");
        wr_reg(12'h010, 32'd7);
        wr_reg(12'h010, 32'd3);
        rd_expect(12'h00C, 32'd5, "R9 retire restores idle");
        wr_reg(12'h010, 32'd5);
        rd_expect(12'h00C, 32'd1023, "R8 masked only so spurious");

        @(negedge clk); sgi_src[2*SW +: SW] = 3'd5;
        set_int(2, 'h20, 0, 1);
        rd_expect(12'h00C, 32'h1402, "R7 source cpu field");
        wr_reg(12'h010, 32'h1402);
        set_int(20, 'h20, 1, 1);
        rd_expect(12'h00C, 32'd20, "R7 non-sgi source zero");
        wr_reg(12'h010, 32'd20);

        // Candidate arrives in the same cycle as the acknowledge read
        @(negedge clk);
        cand_prio[9*PW +: PW] = 8'h30; cand_group[9] = 1; cand_pend[9] = 1;
        bus_valid = 1; bus_write = 0; bus_addr = 12'h00C; cur_tag = "R5 same-cycle arrival";
        @(negedge clk); bus_valid = 0;
        check(bus_rdata == 32'd9, "R5 same-cycle arrival", bus_rdata, 9);
        wr_reg(12'h010, 32'd9);

        wr_reg(12'h000, 32'h03);
        set_int(4, 'h20, 0, 1); wait_cyc(2);
        check(irq_o == 1 && fiq_o == 0, "R4 group0 on irq when unrouted", {irq_o, fiq_o}, 2'b10);
        wr_reg(12'h000, 32'h08); wait_cyc(2);
        check(irq_o == 0 && fiq_o == 0, "R12 both groups off", {irq_o, fiq_o}, 0);
        rd_expect(12'h00C, 32'd1023, "R12 acknowledge spurious");
        set_int(4, 'h20, 0, 0);
        wr_reg(12'h000, 32'h0B);

        cur_tag = "R5 random";
        for (int k = 0; k < 600; k++) begin
            int op;
            op = int'($urandom_range(0, 5));
            if (op <= 1) begin
                set_int(int'($urandom_range(0, N-1)), int'($urandom_range(0, 255)),
                        1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end else if (op == 2) begin
                @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = 12'h00C;
                @(negedge clk); bus_valid = 0;
            end else if (op == 3) begin
                if (stk_id.size() > 0 && $urandom_range(0, 3) != 0) wr_reg(12'h010, 32'(stk_id[$]));
                else wr_reg(12'h010, 32'($urandom_range(0, N-1)));
            end else if (op == 4) begin
                wr_reg(12'h000, 32'($urandom_range(0, 15)));
            end else begin
                wr_reg(12'h004, 32'($urandom_range(0, 255)));
            end
        end
        wait_cyc(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule